// File: doc/BRIEF.md
# I2C Host Register Front-End

This block sits between a processor's byte-wide register port and the byte engine of an I2C host. Software sees five registers: its own bus address, a clock divider setting, control, status and data. The block turns register accesses into byte-level commands on a downstream command stream: open a transfer with an address byte, send a byte, receive a byte, or close the transfer. Each command comes back with a result byte and a no-acknowledge flag. The block keeps the status flags and drives one level-sensitive interrupt line. Bit timing, clock division, target mode and arbitration are handled elsewhere.

The register port and the command stream both use valid/ready handshakes. A register request is accepted only while the block is idle (`reg_ready` high). If the access needs the bus, `reg_ready` stays low until every command it caused has returned its result. The completion pulse `rsp_valid` then marks the end of the access. A stalled command (`cmd_valid` high, `cmd_ready` low) holds its opcode and byte. Results are taken only while `res_ready` is high, which is the case exactly while a command is outstanding.

Top module: `i2c_host_regfront`

## Requirements
- R1: After reset, every register reads 0x00, `irq` is low and no command is pending.
- R2: Register offsets: 0x00 own address (bits 7:1 kept, bit 0 reads 0), 0x04 divider (low DIV_W bits kept), 0x08 control, 0x0C status, 0x10 data. A read of any other offset returns 0x00 and a write to it changes nothing.
- R3: Control bits: bit 0 enable, bit 1 interrupt enable, bit 2 host mode, bit 3 transmit direction, bit 4 repeated start; bits 7:5 read 0. Status bit 3 (busy) follows the host-mode bit of each control write. Clearing host mode while a transfer is open issues a stop command (opcode 3, byte 0x00) and leaves the address unset.
- R4: A control write with bit 0 cleared while enabled is a soft reset. It returns control, divider, status and the data register to 0x00, keeps the own address, and issues a stop if a transfer is open.
- R5: A repeated-start request while a transfer is open issues a stop, unsets the address and clears control bit 4. With no open transfer, bit 4 stays as written.
- R6: A data write while disabled issues no command.
- R7: In host mode with no address set, a data write issues a start command (opcode 0) carrying the byte (bits 7:1 target, bit 0 read). A no-acknowledge sets status bit 0 and leaves the address unset. An acknowledge records the address, clears bit 0 and raises the pending flag.
- R8: With an address set, a data write issues a send command (opcode 1). An acknowledge clears status bit 0 and raises pending. A no-acknowledge sets bit 0, issues a stop and unsets the address, so the next data write starts a transfer.
- R9: A data read returns the stored byte. In host mode, with an address set and bit 3 clear, it also issues a receive command (opcode 2, byte 0x00), stores the result byte and raises pending. In any other case it issues nothing.
- R10: Status bit 1 (pending) clears when software writes 0 to it. Writing 1 leaves it set, and no status write sets it.
- R11: Pending is set only when both enable and interrupt enable are set, and `irq` is high exactly when pending, enable and interrupt enable are all set.
- R12: `reg_ready` is high only while idle. `rsp_valid` follows acceptance by one cycle when no command is needed, and otherwise follows the last command result. A stalled command keeps its opcode and byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register request valid |
| reg_ready | output | 1 | Register request accepted when high with valid |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset |
| reg_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Access completed (one-cycle pulse) |
| rsp_rdata | output | 8 | Read data, valid with rsp_valid (0 for writes) |
| irq | output | 1 | Level interrupt |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command accepted |
| cmd_op | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| cmd_byte | output | 8 | Command byte |
| res_valid | input | 1 | Result valid |
| res_ready | output | 1 | Result accepted |
| res_byte | input | 8 | Received byte |
| res_nack | input | 1 | Target did not acknowledge |

## Verification
The hardest case to reach is a data byte rejected after a successful address phase. That path needs two back-to-back commands (send, then stop) while the register port stays stalled, and the address must afterwards read as unset. The bench gets there by driving the responder's ack decision from the command content: only target 0x50 acknowledges, and the data byte 0xEE is always refused. A later data write must then show up as a start command. The same responder stalls every command for one cycle, so the hold rule on the command stream is exercised on every transfer.

// File: rtl/i2c_host_pkg.sv
package i2c_host_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  // control register bit positions
  localparam int CTL_EN  = 0;
  localparam int CTL_IEN = 1;
  localparam int CTL_MST = 2;
  localparam int CTL_TX  = 3;
  localparam int CTL_RS  = 4;
  localparam int CTL_W   = 5;

  // status register bit positions
  localparam int ST_NACK = 0;
  localparam int ST_PEND = 1;
  localparam int ST_ARB  = 2;
  localparam int ST_BUSY = 3;

  // register offsets
  localparam int OFS_OWN  = 'h00;
  localparam int OFS_DIV  = 'h04;
  localparam int OFS_CTL  = 'h08;
  localparam int OFS_STAT = 'h0C;
  localparam int OFS_DATA = 'h10;
endpackage

// File: rtl/i2c_host_cmd_port.sv
module i2c_host_cmd_port
  import i2c_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  bus_op_e           go_op,
  input  logic [BYTE_W-1:0] go_byte,
  output logic              done,
  output logic              done_nack,
  output logic [BYTE_W-1:0] done_byte,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [BYTE_W-1:0] cmd_byte,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [BYTE_W-1:0] res_byte,
  input  logic              res_nack
);
  typedef enum logic [1:0] {CP_IDLE, CP_REQ, CP_WAIT} cp_state_e;
  cp_state_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= CP_IDLE;
      cmd_op   <= 2'(OP_STOP);
      cmd_byte <= '0;
    end else if (go) begin
      st_q     <= CP_REQ;
      cmd_op   <= go_op;
      cmd_byte <= go_byte;
    end else begin
      case (st_q)
        CP_REQ:  if (cmd_ready) st_q <= CP_WAIT;
        CP_WAIT: if (res_valid) st_q <= CP_IDLE;
        default: st_q <= CP_IDLE;
      endcase
    end
  end

  assign cmd_valid = (st_q == CP_REQ);
  assign res_ready = (st_q == CP_WAIT);
  assign done      = res_ready && res_valid;
  assign done_nack = res_nack;
  assign done_byte = res_byte;

  // a stalled command must not change under the receiver
  assert_cmd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));

  // a new command may only be launched when the previous one is finished
  assert_go_when_free_R12: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (st_q == CP_IDLE || done));
endmodule

// File: rtl/i2c_host_irq.sv
module i2c_host_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ien,
  input  logic raise,
  input  logic clear,
  input  logic flush,
  output logic pending,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)             pending <= 1'b0;
    else if (flush || clear) pending <= 1'b0;
    else if (raise && en && ien) pending <= 1'b1;
  end

  assign irq = pending && en && ien;

  assert_pend_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(en && ien));

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !pending);
endmodule

// File: rtl/i2c_host_regfront.sv
module i2c_host_regfront
  import i2c_host_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DIV_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  output logic              reg_ready,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_rdata,
  output logic              irq,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [7:0]        cmd_byte,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [7:0]        res_byte,
  input  logic              res_nack
);
  localparam logic [ADDR_W-1:0] A_OWN  = ADDR_W'(OFS_OWN);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(OFS_DIV);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);

  typedef enum logic [1:0] {FE_IDLE, FE_BUS, FE_STOP} fe_state_e;

  fe_state_e         st_q, st_d;
  logic [7:1]        own_q, own_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [CTL_W-1:0]  ctl_q, ctl_d;
  logic              nack_q, nack_d;
  logic              busy_q, busy_d;
  logic              aset_q, aset_d;
  logic [7:0]        rbuf_q, rbuf_d;
  logic              rsp_v_d;
  logic [7:0]        rsp_data_d;
  logic              go;
  bus_op_e           go_op;
  logic [7:0]        go_byte;
  logic              raise, clr_pend, flush;
  logic              done, done_nack;
  logic [7:0]        done_byte;
  logic              pending;
  logic [7:0]        stat_rd;
  logic              accept;

  assign reg_ready = (st_q == FE_IDLE);
  assign accept    = reg_valid && reg_ready;

  always_comb begin
    stat_rd          = '0;
    stat_rd[ST_NACK] = nack_q;
    stat_rd[ST_PEND] = pending;
    stat_rd[ST_ARB]  = 1'b0;
    stat_rd[ST_BUSY] = busy_q;
  end

  always_comb begin
    st_d       = st_q;
    own_d      = own_q;
    div_d      = div_q;
    ctl_d      = ctl_q;
    nack_d     = nack_q;
    busy_d     = busy_q;
    aset_d     = aset_q;
    rbuf_d     = rbuf_q;
    rsp_v_d    = 1'b0;
    rsp_data_d = rsp_rdata;
    go         = 1'b0;
    go_op      = OP_STOP;
    go_byte    = '0;
    raise      = 1'b0;
    clr_pend   = 1'b0;
    flush      = 1'b0;

    case (st_q)
      FE_IDLE: begin
        if (accept) begin
          rsp_data_d = '0;
          if (!reg_we) begin
            case (reg_addr)
              A_OWN:   rsp_data_d = {own_q, 1'b0};
              A_DIV:   rsp_data_d = 8'(div_q);
              A_CTL:   rsp_data_d = 8'(ctl_q);
              A_STAT:  rsp_data_d = stat_rd;
              A_DATA:  rsp_data_d = rbuf_q;
              default: rsp_data_d = '0;
            endcase
            if (reg_addr == A_DATA && ctl_q[CTL_MST] && aset_q && !ctl_q[CTL_TX]) begin
              go    = 1'b1;
              go_op = OP_RECV;
            end
          end else begin
            case (reg_addr)
              A_OWN: own_d = reg_wdata[7:1];
              A_DIV: div_d = reg_wdata[DIV_W-1:0];
              A_CTL: begin
                if (ctl_q[CTL_EN] && !reg_wdata[CTL_EN]) begin
                  // soft reset: everything but the own address
                  flush  = 1'b1;
                  ctl_d  = '0;
                  div_d  = '0;
                  nack_d = 1'b0;
                  busy_d = 1'b0;
                  rbuf_d = '0;
                  aset_d = 1'b0;
                  if (aset_q) begin
                    go    = 1'b1;
                    go_op = OP_STOP;
                  end
                end else begin
                  ctl_d  = reg_wdata[CTL_W-1:0];
                  busy_d = reg_wdata[CTL_MST];
                  if (!reg_wdata[CTL_MST] && aset_q) begin
                    go     = 1'b1;
                    go_op  = OP_STOP;
                    aset_d = 1'b0;
                  end else if (reg_wdata[CTL_RS] && aset_q) begin
                    go            = 1'b1;
                    go_op         = OP_STOP;
                    aset_d        = 1'b0;
                    ctl_d[CTL_RS] = 1'b0;
                  end
                end
              end
              A_STAT: begin
                if (pending && !reg_wdata[ST_PEND]) clr_pend = 1'b1;
              end
              A_DATA: begin
                if (ctl_q[CTL_EN] && ctl_q[CTL_MST]) begin
                  go      = 1'b1;
                  go_op   = aset_q ? OP_SEND : OP_START;
                  go_byte = reg_wdata;
                end
              end
              default: ;
            endcase
          end
          if (go) st_d = FE_BUS;
          else    rsp_v_d = 1'b1;
        end
      end

      FE_BUS: begin
        if (done) begin
          st_d    = FE_IDLE;
          rsp_v_d = 1'b1;
          case (cmd_op)
            OP_START: begin
              if (done_nack) nack_d = 1'b1;
              else begin
                nack_d = 1'b0;
                aset_d = 1'b1;
                raise  = 1'b1;
              end
            end
            OP_SEND: begin
              if (done_nack) begin
                nack_d  = 1'b1;
                aset_d  = 1'b0;
                go      = 1'b1;
                go_op   = OP_STOP;
                st_d    = FE_STOP;
                rsp_v_d = 1'b0;
              end else begin
                nack_d = 1'b0;
                raise  = 1'b1;
              end
            end
            OP_RECV: begin
              if (!done_nack) begin
                rbuf_d = done_byte;
                raise  = 1'b1;
              end
            end
            default: ;
          endcase
        end
      end

      FE_STOP: begin
        if (done) begin
          st_d    = FE_IDLE;
          rsp_v_d = 1'b1;
        end
      end

      default: st_d = FE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= FE_IDLE;
      own_q     <= '0;
      div_q     <= '0;
      ctl_q     <= '0;
      nack_q    <= 1'b0;
      busy_q    <= 1'b0;
      aset_q    <= 1'b0;
      rbuf_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      st_q      <= st_d;
      own_q     <= own_d;
      div_q     <= div_d;
      ctl_q     <= ctl_d;
      nack_q    <= nack_d;
      busy_q    <= busy_d;
      aset_q    <= aset_d;
      rbuf_q    <= rbuf_d;
      rsp_valid <= rsp_v_d;
      rsp_rdata <= rsp_data_d;
    end
  end

  i2c_host_cmd_port u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .go_op     (go_op),
    .go_byte   (go_byte),
    .done      (done),
    .done_nack (done_nack),
    .done_byte (done_byte),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_byte  (cmd_byte),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_byte  (res_byte),
    .res_nack  (res_nack)
  );

  i2c_host_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctl_q[CTL_EN]),
    .ien     (ctl_q[CTL_IEN]),
    .raise   (raise),
    .clear   (clr_pend),
    .flush   (flush),
    .pending (pending),
    .irq     (irq)
  );

  // register port stays stalled while a command is on the bus
  assert_stall_on_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !reg_ready);

  // a data write while disabled completes at once without any command
  assert_disabled_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && reg_we && reg_addr == A_DATA && !ctl_q[CTL_EN]) |=> (rsp_valid && !cmd_valid));

  // a refused data byte is followed by a stop command
  assert_stop_after_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FE_BUS && done && cmd_op == 2'(OP_SEND) && done_nack)
      |=> (st_q == FE_STOP && cmd_valid && cmd_op == 2'(OP_STOP)));
endmodule

// File: tb/i2c_host_regfront_test.sv
module i2c_host_regfront_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_valid, reg_we;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_ready, rsp_valid, irq;
  logic [7:0] rsp_rdata;
  logic       cmd_valid, cmd_ready, res_valid, res_ready, res_nack;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte, res_byte;

  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] rx_next = 8'hC0;

  logic [7:0] exp_rd[$];
  string      exp_rd_tag[$];
  logic [9:0] exp_cmd[$];
  string      exp_cmd_tag[$];

  i2c_host_regfront uut (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
    .res_valid(res_valid), .res_ready(res_ready), .res_byte(res_byte), .res_nack(res_nack)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares every completion against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_rd.size() == 0) check("R12 unexpected completion", 1, 0);
      else begin
        string t;
        t = exp_rd_tag.pop_front();
        check(t, rsp_rdata, exp_rd.pop_front());
      end
    end
  end

  // target responder: only 0x50 acknowledges its address, 0xEE is refused
  initial begin
    cmd_ready = 1'b0; res_valid = 1'b0; res_byte = '0; res_nack = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid) begin
        logic [1:0] op;
        logic [7:0] by;
        op = cmd_op;
        by = cmd_byte;
        @(negedge clk);
        check("R12 stalled command held", {cmd_valid, cmd_op, cmd_byte}, {1'b1, op, by});
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        if (exp_cmd.size() == 0) check("R6 unexpected command", {op, by}, 0);
        else begin
          string t;
          t = exp_cmd_tag.pop_front();
          check(t, {op, by}, exp_cmd.pop_front());
        end
        res_nack = 1'b0;
        res_byte = '0;
        case (op)
          2'd0: res_nack = (by[7:1] != 7'h50);
          2'd1: res_nack = (by == 8'hEE);
          2'd2: begin res_byte = rx_next; rx_next = rx_next + 8'd1; end
          default: ;
        endcase
        @(negedge clk);
        check("R12 result ready while waiting", res_ready, 1);
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
      end
    end
  end

  task automatic acc(input logic we, input logic [4:0] a, input logic [7:0] wd,
                     input logic [7:0] exp, input string tag, input int lat);
    int n;
    @(negedge clk);
    reg_valid = 1'b1; reg_we = we; reg_addr = a; reg_wdata = wd;
    exp_rd.push_back(we ? 8'h00 : exp);
    exp_rd_tag.push_back(tag);
    while (!reg_ready) @(negedge clk);
    @(negedge clk);
    reg_valid = 1'b0;
    n = 0;
    while (!rsp_valid) begin @(negedge clk); n++; end
    if (lat >= 0) check({"R12 latency of ", tag}, n, lat);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input string tag, input int lat);
    acc(1'b1, a, d, 8'h00, tag, lat);
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] e, input string tag, input int lat);
    acc(1'b0, a, 8'h00, e, tag, lat);
  endtask

  task automatic excmd(input logic [1:0] op, input logic [7:0] b, input string tag);
    exp_cmd.push_back({op, b});
    exp_cmd_tag.push_back(tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check("R12 watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_valid = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", irq, 0);
    check("R1 no command after reset", cmd_valid, 0);
    check("R12 ready when idle", reg_ready, 1);
    rd(5'h00, 8'h00, "R1 own reset", 0);
    rd(5'h04, 8'h00, "R1 div reset", 0);
    rd(5'h08, 8'h00, "R1 ctl reset", 0);
    rd(5'h0C, 8'h00, "R1 status reset", 0);
    rd(5'h10, 8'h00, "R1 data reset", 0);

    wr(5'h00, 8'hA7, "R2 own write", 0);
    rd(5'h00, 8'hA6, "R2 own bit0 reads 0", 0);
    wr(5'h04, 8'hFF, "R2 div write", 0);
    rd(5'h04, 8'h3F, "R2 div masked", 0);
    wr(5'h14, 8'h55, "R2 unmapped write", 0);
    rd(5'h14, 8'h00, "R2 unmapped read", 0);
    rd(5'h18, 8'h00, "R2 unmapped read 2", 0);

    wr(5'h08, 8'hFF, "R3 ctl write", 0);
    rd(5'h08, 8'h1F, "R5 restart kept without transfer", 0);
    rd(5'h0C, 8'h08, "R3 busy on host mode", 0);
    wr(5'h08, 8'h00, "R4 soft reset", 0);
    rd(5'h08, 8'h00, "R4 ctl after soft reset", 0);
    rd(5'h0C, 8'h00, "R4 status after soft reset", 0);
    rd(5'h04, 8'h00, "R4 div after soft reset", 0);
    rd(5'h00, 8'hA6, "R4 own kept", 0);

    wr(5'h10, 8'hA0, "R6 disabled data write", 0);
    repeat (4) @(negedge clk);
    check("R6 no command while disabled", cmd_valid, 0);

    wr(5'h08, 8'h0F, "R3 enable host tx", 0);
    rd(5'h0C, 8'h08, "R3 busy set", 0);
    excmd(2'd0, 8'hA2, "R7 start to 0x51");
    wr(5'h10, 8'hA2, "R7 address write refused", -1);
    rd(5'h0C, 8'h09, "R7 nack flag", 0);
    check("R11 irq low after refusal", irq, 0);
    excmd(2'd0, 8'hA0, "R7 start to 0x50");
    wr(5'h10, 8'hA0, "R7 address write accepted", -1);
    rd(5'h0C, 8'h0A, "R7 nack clear pending set", 0);
    check("R11 irq high", irq, 1);
    wr(5'h0C, 8'hFF, "R10 write one", 0);
    rd(5'h0C, 8'h0A, "R10 pending kept on 1", 0);
    wr(5'h0C, 8'h00, "R10 write zero", 0);
    rd(5'h0C, 8'h08, "R10 pending cleared", 0);
    check("R11 irq dropped", irq, 0);

    excmd(2'd1, 8'h33, "R8 send 0x33");
    wr(5'h10, 8'h33, "R8 data accepted", -1);
    rd(5'h0C, 8'h0A, "R8 pending after send", 0);
    wr(5'h0C, 8'h00, "R10 clear", 0);
    excmd(2'd1, 8'hEE, "R8 send refused byte");
    excmd(2'd3, 8'h00, "R8 stop after refusal");
    wr(5'h10, 8'hEE, "R8 data refused", -1);
    rd(5'h0C, 8'h09, "R8 nack after refusal", 0);
    excmd(2'd0, 8'hA0, "R8 address unset so start again");
    wr(5'h10, 8'hA0, "R8 restart transfer", -1);
    rd(5'h0C, 8'h0A, "R8 accepted again", 0);
    wr(5'h0C, 8'h00, "R10 clear", 0);

    excmd(2'd3, 8'h00, "R5 stop on repeated start");
    wr(5'h08, 8'h1F, "R5 repeated start", -1);
    rd(5'h08, 8'h0F, "R5 restart bit cleared", 0);
    excmd(2'd0, 8'hA1, "R7 start read to 0x50");
    wr(5'h10, 8'hA1, "R7 read address", -1);
    wr(5'h0C, 8'h00, "R10 clear", 0);

    wr(5'h08, 8'h07, "R9 receive direction", 0);
    excmd(2'd2, 8'h00, "R9 receive 1");
    rd(5'h10, 8'h00, "R9 first read returns old byte", -1);
    rd(5'h0C, 8'h0A, "R9 pending after receive", 0);
    check("R11 irq after receive", irq, 1);
    wr(5'h0C, 8'h00, "R10 clear", 0);
    excmd(2'd2, 8'h00, "R9 receive 2");
    rd(5'h10, 8'hC0, "R9 second read", -1);
    wr(5'h0C, 8'h00, "R10 clear", 0);
    wr(5'h08, 8'h05, "R11 interrupt enable off", 0);
    excmd(2'd2, 8'h00, "R9 receive 3");
    rd(5'h10, 8'hC1, "R9 third read", -1);
    rd(5'h0C, 8'h08, "R11 no pending when masked", 0);
    check("R11 irq masked", irq, 0);
    wr(5'h08, 8'h0D, "R9 transmit direction", 0);
    rd(5'h10, 8'hC2, "R9 no fetch in transmit", 0);

    excmd(2'd3, 8'h00, "R3 stop on host clear");
    wr(5'h08, 8'h01, "R3 leave host mode", -1);
    rd(5'h0C, 8'h00, "R3 busy cleared", 0);
    wr(5'h08, 8'h07, "R9 host rx without address", 0);
    rd(5'h10, 8'hC2, "R9 no fetch without address", 0);

    excmd(2'd0, 8'hA0, "R4 open transfer");
    wr(5'h10, 8'hA0, "R4 open transfer", -1);
    check("R11 irq before soft reset", irq, 1);
    excmd(2'd3, 8'h00, "R4 stop on soft reset");
    wr(5'h08, 8'h00, "R4 soft reset with transfer", -1);
    check("R4 irq after soft reset", irq, 0);
    rd(5'h0C, 8'h00, "R4 status cleared", 0);
    rd(5'h10, 8'h00, "R4 data cleared", 0);
    rd(5'h00, 8'hA6, "R4 own kept again", 0);

    repeat (6) @(negedge clk);
    check("R12 all commands issued", exp_cmd.size(), 0);
    check("R12 all completions seen", exp_rd.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule